// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block makes a periodic time base for a processor core. A 24-bit counter counts down by one on every selected tick while the timer is running. When it steps from 1 to 0 it sets a sticky timeout flag and, if interrupts are on, sends a one-cycle interrupt request. On the tick after it reaches zero it reloads itself from a reload register, so the period is (reload + 1) ticks.

Software uses the block through a small word-addressed register bus with four slots: control/status, reload, current count and pend. The tick comes from the core clock, either directly or divided by 8, or from an external tick line. That line is synchronised and edge-detected. A debug-halt input freezes counting. A pend write raises the interrupt at once, without waiting for a timeout.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-count registers read 0 and `irq_o` is low.
- R2: While the run bit (control bit 0, slot 0) is 1, every tick lowers the current count (slot 2, read back zero-extended) by one. The current count stays unchanged while the run bit is 0.
- R3: A tick that takes the count from 1 to 0 sets the sticky flag (control/status bit 16). The next tick at zero loads the reload value (slot 1, low 24 bits kept, upper bits read 0).
- R4: With a reload value of 0 the count stays at 0 and the flag is never set.
- R5: A timeout drives `irq_o` high for exactly one cycle only when the interrupt-enable bit (control bit 1) is 1.
- R6: A write of any data to slot 2 loads the reload value into the count and clears the flag.
- R7: A read strobe on slot 0 clears the flag after the read value has been returned.
- R8: A write to slot 3 with data bit 0 set gives a one-cycle `irq_o` pulse whatever the interrupt-enable bit is. It leaves the flag alone. Slot 3 reads 0, and a write with bit 0 clear does nothing.
- R9: While `dbg_halt_i` is high the count holds its value. Counting picks up again when the input is released.
- R10: With the source bit (control bit 2) at 1 the tick is the core clock. The divide bit (control bit 3) then gives one tick every 8 cycles, with the divider cleared while the run bit is 0.
- R11: With the source bit at 0, each rising edge of `ext_tick_i` gives exactly one tick, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register slot select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only side effect: flag clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| ext_tick_i | input | 1 | External reference tick |
| dbg_halt_i | input | 1 | Debug halt, freezes counting |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
Register writes, count steps, flag changes and the interrupt pulse all appear in the cycle that follows the clock edge taking the write or tick. The bench drives each write for exactly one edge and samples at the next falling edge. Read data is combinational, so counts and flags are read in the low half of the same cycle, before another tick can land. A core-clock tick lands on every edge after the run bit is written. With the divider on, the 8th and 16th edges each bring a tick. An external edge counts two edges after it is seen through the synchroniser, and the bench waits out that delay before it compares.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic [1:0] {
      SLOT_CTRL    = 2'd0,
      SLOT_RELOAD  = 2'd1,
      SLOT_CURRENT = 2'd2,
      SLOT_PEND    = 2'd3
   } slot_e;

   localparam int CB_RUN   = 0;
   localparam int CB_IRQEN = 1;
   localparam int CB_CORE  = 2;
   localparam int CB_DIV   = 3;
   localparam int CB_FLAG  = 16;
endpackage

// File: rtl/tick_timer_tickgen.sv
module tick_timer_tickgen #(
   parameter int PRESCALE    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic halt,
   input  logic use_core,
   input  logic use_div,
   input  logic ext_tick,
   output logic tick
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("PRESCALE must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev_q;
   logic                   ext_rise;
   logic                   core_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= ext_tick;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev_q <= 1'b0;
      else        ext_prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_prev_q;

   if (PRESCALE > 1) begin : g_prescale
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre_q;
      logic          pre_wrap;

      assign pre_wrap = (pre_q == PW'(PRESCALE - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           pre_q <= '0;
         else if (!run || !use_core || !use_div) pre_q <= '0;
         else if (!halt)                       pre_q <= pre_wrap ? '0 : pre_q + PW'(1);
      end

      assign core_tick = use_div ? pre_wrap : 1'b1;

      // R10
      prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run && use_core && use_div && tick) |=> !tick);
   end else begin : g_noprescale
      logic unused_div;
      assign unused_div = use_div;
      assign core_tick  = 1'b1;
   end

   assign tick = run & ~halt & (use_core ? core_tick : ext_rise);

   // R11
   ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_core && tick) |=> !tick);
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   assign wrap = tick & ~load & (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= reload_val;
      else if (tick) count <= (count == '0) ? reload_val : count - CNT_W'(1);
   end

   // R2
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count != '0) |=> count == $past(count) - CNT_W'(1));

   // R6
   force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(reload_val));

   // R4
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count == '0 && reload_val == '0) |=> (count == '0 && !wrap));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int DATA_W      = 32,
   parameter int PRESCALE    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_tick_i,
   input  logic              dbg_halt_i,
   output logic              irq_o
);
   if (CNT_W < 2 || CNT_W >= DATA_W || CB_FLAG >= DATA_W) begin : g_bad_width
      $error("CNT_W must lie in 2..DATA_W-1 and the flag bit must fit DATA_W");
   end

   logic             run_q, irqen_q, core_q, div_q, flag_q, irq_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cur_count;
   logic             tick, wrap;
   logic             wr_ctrl, wr_reload, wr_cur, pend_go, rd_ctrl;
   logic             unused_wdata_bits;

   assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CNT_W];

   assign wr_ctrl   = bus_wr && (bus_addr == SLOT_CTRL);
   assign wr_reload = bus_wr && (bus_addr == SLOT_RELOAD);
   assign wr_cur    = bus_wr && (bus_addr == SLOT_CURRENT);
   assign pend_go   = bus_wr && (bus_addr == SLOT_PEND) && bus_wdata[0];
   assign rd_ctrl   = bus_rd && !bus_wr && (bus_addr == SLOT_CTRL);

   tick_timer_tickgen #(
      .PRESCALE    (PRESCALE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tickgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .halt     (dbg_halt_i),
      .use_core (core_q),
      .use_div  (div_q),
      .ext_tick (ext_tick_i),
      .tick     (tick)
   );

   tick_timer_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (wr_cur),
      .reload_val (reload_q),
      .count      (cur_count),
      .wrap       (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         irqen_q <= 1'b0;
         core_q  <= 1'b0;
         div_q   <= 1'b0;
      end else if (wr_ctrl) begin
         run_q   <= bus_wdata[CB_RUN];
         irqen_q <= bus_wdata[CB_IRQEN];
         core_q  <= bus_wdata[CB_CORE];
         div_q   <= bus_wdata[CB_DIV];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q <= '0;
      else if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_q <= 1'b0;
      else if (wrap)              flag_q <= 1'b1;
      else if (rd_ctrl || wr_cur) flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (wrap & irqen_q) | pend_go;
   end

   assign irq_o = irq_q;

   always_comb begin
      bus_rdata = '0;
      case (slot_e'(bus_addr))
         SLOT_CTRL: begin
            bus_rdata[CB_RUN]   = run_q;
            bus_rdata[CB_IRQEN] = irqen_q;
            bus_rdata[CB_CORE]  = core_q;
            bus_rdata[CB_DIV]   = div_q;
            bus_rdata[CB_FLAG]  = flag_q;
         end
         SLOT_RELOAD:  bus_rdata = DATA_W'(reload_q);
         SLOT_CURRENT: bus_rdata = DATA_W'(cur_count);
         default:      bus_rdata = '0;
      endcase
   end

   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag_q);

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !wrap) |=> !flag_q);

   // R8
   pend_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_go |=> irq_o);

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irqen_q && !pend_go) |=> !irq_o);

   // R9
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt_i && !wr_cur) |=> $stable(cur_count));
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/100ps
module tick_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ext_tick_i = 1'b0;
   logic        dbg_halt_i = 1'b0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tick_timer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ext_tick_i (ext_tick_i),
      .dbg_halt_i (dbg_halt_i),
      .irq_o      (irq_o)
   );

   always @(posedge clk) if (irq_o) irq_seen++;

   localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_CUR = 2'd2, A_PEND = 2'd3;
   localparam logic [31:0] FLAG = 32'h0001_0000;

   typedef struct packed {
      logic [23:0] reload;
      logic [7:0]  steps;
      logic [23:0] exp_cnt;
      logic        exp_flag;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{24'd5, 8'd3,  24'd2, 1'b0},
      '{24'd5, 8'd5,  24'd0, 1'b1},
      '{24'd5, 8'd6,  24'd5, 1'b1},
      '{24'd3, 8'd10, 24'd1, 1'b1},
      '{24'd0, 8'd7,  24'd0, 1'b0},
      '{24'd1, 8'd1,  24'd0, 1'b1},
      '{24'd1, 8'd4,  24'd1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int base;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
      peek(A_RELOAD, v); chk("R1 reload", v, 32'h0);
      peek(A_CUR, v);    chk("R1 current", v, 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);

      // R2 R3 R4 vector walk on core clock ticks
      for (int i = 0; i < NVEC; i++) begin
         wr(A_CTRL, 32'h0);
         wr(A_RELOAD, {8'h0, VECS[i].reload});
         wr(A_CUR, 32'hDEAD_BEEF);
         wr(A_CTRL, 32'h5);
         repeat (int'(VECS[i].steps)) @(negedge clk);
         peek(A_CUR, v);
         chk(VECS[i].reload == 0 ? "R4 count" : "R2 count", v, {8'h0, VECS[i].exp_cnt});
         peek(A_CTRL, v);
         chk(VECS[i].reload == 0 ? "R4 flag" : "R3 flag", v & FLAG, VECS[i].exp_flag ? FLAG : 32'h0);
      end

      // R2 stopped timer holds count
      wr(A_CTRL, 32'h4);
      wr(A_RELOAD, 32'd9);
      wr(A_CUR, 32'h0);
      repeat (5) @(negedge clk);
      peek(A_CUR, v); chk("R2 run off", v, 32'd9);

      // R5 interrupt pulse with enable
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'd2);
      wr(A_CUR, 32'h0);
      base = irq_seen;
      wr(A_CTRL, 32'h7);
      chk("R5 irq before", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R5 irq early", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R5 irq pulse", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R5 irq one cycle", {31'b0, irq_o}, 32'h0);
      peek(A_CUR, v); chk("R3 reload after zero", v, 32'd2);
      repeat (6) @(negedge clk);
      chk("R5 pulse count", irq_seen - base, 3);

      // R5 no interrupt when disabled, flag still set
      wr(A_CTRL, 32'h0);
      wr(A_CUR, 32'h0);
      base = irq_seen;
      wr(A_CTRL, 32'h5);
      repeat (8) @(negedge clk);
      chk("R5 masked", irq_seen - base, 0);
      peek(A_CTRL, v); chk("R3 flag masked", v & FLAG, FLAG);

      // R7 read of ctrl clears flag
      wr(A_CTRL, 32'h0);
      peek(A_CTRL, v); chk("R7 flag before read", v & FLAG, FLAG);
      @(negedge clk);
      bus_addr = A_CTRL; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      peek(A_CTRL, v); chk("R7 flag after read", v & FLAG, 32'h0);

      // R8 pend request
      wr(A_PEND, 32'h0);
      chk("R8 pend zero data", {31'b0, irq_o}, 32'h0);
      wr(A_PEND, 32'h1);
      chk("R8 pend pulse", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R8 pend one cycle", {31'b0, irq_o}, 32'h0);
      peek(A_PEND, v); chk("R8 pend reads 0", v, 32'h0);
      peek(A_CTRL, v); chk("R8 flag untouched", v & FLAG, 32'h0);

      // R6 write of any data forces reload, clears flag
      wr(A_RELOAD, 32'hFFAB_CDEF);
      peek(A_RELOAD, v); chk("R3 reload width", v, 32'h00AB_CDEF);
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'd1);
      wr(A_CUR, 32'h0);
      wr(A_CTRL, 32'h5);
      wr(A_CTRL, 32'h0);
      peek(A_CTRL, v); chk("R6 flag set", v & FLAG, FLAG);
      wr(A_RELOAD, 32'h00AB_CDEF);
      wr(A_CUR, 32'h1234_5678);
      peek(A_CUR, v);  chk("R6 forced reload", v, 32'h00AB_CDEF);
      peek(A_CTRL, v); chk("R6 flag cleared", v & FLAG, 32'h0);

      // R9 debug halt freezes counting
      wr(A_RELOAD, 32'd50);
      wr(A_CUR, 32'h0);
      wr(A_CTRL, 32'h5);
      dbg_halt_i = 1'b1;
      repeat (5) @(negedge clk);
      peek(A_CUR, v); chk("R9 halted", v, 32'd50);
      dbg_halt_i = 1'b0;
      repeat (3) @(negedge clk);
      peek(A_CUR, v); chk("R9 resumed", v, 32'd47);

      // R10 divide by 8
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'd100);
      wr(A_CUR, 32'h0);
      wr(A_CTRL, 32'hD);
      repeat (15) @(negedge clk);
      peek(A_CUR, v); chk("R10 div 15 edges", v, 32'd99);
      @(negedge clk);
      peek(A_CUR, v); chk("R10 div 16 edges", v, 32'd98);

      // R11 external tick edges
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'd10);
      wr(A_CUR, 32'h0);
      wr(A_CTRL, 32'h1);
      for (int p = 0; p < 4; p++) begin
         ext_tick_i = 1'b1;
         repeat (3) @(negedge clk);
         ext_tick_i = 1'b0;
         repeat (3) @(negedge clk);
         peek(A_CUR, v); chk("R11 ext edge", v, 32'd9 - p);
      end
      repeat (4) @(negedge clk);
      peek(A_CUR, v); chk("R11 ext idle", v, 32'd6);

      finish_run();
   end
endmodule